// File: doc/BRIEF.md
# Shared Bit Counting Unit

This block counts bits in a 32-bit operand in one of three ways: the length of the zero run at the top end (leading zeros), the length of the zero run at the bottom end (trailing zeros), or the total number of set bits (population count). All three use one datapath. A 2-bit operation select sets up the operand and the counting chain. The result is a 6-bit count, wide enough to hold 32.

The datapath is a single chain of one-bit accumulators that runs from the least significant position upward. For leading zeros, the operand is bit-reversed first, so its top end becomes the bottom of the chain. For both zero counts, the conditioned operand is then inverted, so that zero bits are counted as ones. A ripple enable travels up the chain next to the accumulators. It is used only for the zero counts, and it switches off every counter above the first position whose bit breaks the run. For population count the enable is held high throughout, so every set bit is added.

The unit is purely combinational. It sits inside an execution stage, which supplies the operand and select and takes the count in the same cycle.

Top module: `bit_count_unit`

## Requirements
- R1: With select 2'b10 the count equals the number of bits set to 1 in the operand.
- R2: With select 2'b01 the count equals the number of consecutive 0 bits starting at bit 0 and going upward.
- R3: With select 2'b00 the count equals the number of consecutive 0 bits starting at bit 31 and going downward.
- R4: An all-zero operand gives 32 for select 2'b00 and 2'b01, and 0 for select 2'b10.
- R5: An all-ones operand gives 0 for select 2'b00 and 2'b01, and 32 for select 2'b10.
- R6: Select 2'b11 behaves exactly as select 2'b10 (population count).
- R7: The count follows operand and select combinationally, with no clock and no stored state.
- R8: The count never exceeds 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | Operand to be counted |
| opSel | input | 2 | Operation: 00 leading zeros, 01 trailing zeros, 10 or 11 set-bit count |
| countOut | output | 6 | Resulting count, 0 to 32 |

## Verification
The unit has no registers, so every result is due in the same cycle that its operand and select are applied. The bench changes its inputs on the falling clock edge and reads the count a quarter period later. This leaves time for the logic to settle and keeps the read away from any rising edge. There is never a cycle of latency to account for, so each check compares the count against a reference computed from that one input pair.

// File: rtl/bit_count_pkg.sv
package bit_count_pkg;
  typedef enum logic [1:0] {
    OP_LEAD  = 2'b00,
    OP_TRAIL = 2'b01,
    OP_POP   = 2'b10,
    OP_POP2  = 2'b11
  } bitOp_e;

  typedef struct packed {
    logic reverseEn;
    logic invertEn;
    logic chainEn;
  } bitCtrl_t;
endpackage

// File: rtl/bit_count_ctrl.sv
module bit_count_ctrl
  import bit_count_pkg::*;
(
  input  logic [1:0] opSel,
  output bitCtrl_t   ctrl
);
  always_comb begin
    ctrl = '0;
    unique case (bitOp_e'(opSel))
      OP_LEAD:  ctrl = '{reverseEn: 1'b1, invertEn: 1'b1, chainEn: 1'b1};
      OP_TRAIL: ctrl = '{reverseEn: 1'b0, invertEn: 1'b1, chainEn: 1'b1};
      default:  ctrl = '{reverseEn: 1'b0, invertEn: 1'b0, chainEn: 1'b0}; // R6
    endcase
  end

  always_comb begin
    if (opSel[1]) a_r6_pop_plain: assert (!ctrl.chainEn && !ctrl.invertEn && !ctrl.reverseEn);
  end
endmodule

// File: rtl/bit_count_dp.sv
module bit_count_dp
  import bit_count_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] opA,
  input  bitCtrl_t         ctrl,
  output logic [CNT_W-1:0] countOut
);
  logic [WIDTH-1:0] revVec;
  logic [WIDTH-1:0] condVec;
  logic [WIDTH-1:0] cntBits;
  logic [WIDTH-1:0] runEn;
  logic [CNT_W-1:0] acc [0:WIDTH];

  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign revVec[i] = opA[WIDTH-1-i];
  end

  assign condVec = ctrl.reverseEn ? revVec : opA;
  assign cntBits = ctrl.invertEn ? ~condVec : condVec;

  assign acc[0] = '0;
  for (genvar i = 0; i < WIDTH; i++) begin : g_chain
    if (i == 0) begin : g_first
      assign runEn[i] = ctrl.chainEn ? cntBits[i] : 1'b1;
    end else begin : g_rest
      assign runEn[i] = ctrl.chainEn ? (runEn[i-1] & cntBits[i]) : 1'b1;
    end
    assign acc[i+1] = acc[i] + CNT_W'(runEn[i] & cntBits[i]);
  end

  assign countOut = acc[WIDTH];

  always_comb begin
    a_r8_max_count: assert (countOut <= CNT_W'(WIDTH));
  end
endmodule

// File: rtl/bit_count_unit.sv
module bit_count_unit
  import bit_count_pkg::*;
(
  input  logic [31:0] opA,
  input  logic [1:0]  opSel,
  output logic [5:0]  countOut
);
  bitCtrl_t ctrl;

  bit_count_ctrl u_ctrl (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  bit_count_dp #(.WIDTH(32)) u_dp (
    .opA      (opA),
    .ctrl     (ctrl),
    .countOut (countOut)
  );

  always_comb begin
    if (opSel[1]) a_r1_pop_match: assert (countOut == 6'($countones(opA)));
    if (opSel == 2'b01 && countOut < 6'd32) a_r2_trail_stop: assert (opA[countOut[4:0]]);
    if (opSel == 2'b00 && countOut < 6'd32) a_r3_lead_stop: assert (opA[5'd31 - countOut[4:0]]);
    if (!opSel[1] && opA == '0) a_r4_zero_full: assert (countOut == 6'd32);
    if (!opSel[1] && opA == '1) a_r5_ones_none: assert (countOut == 6'd0);
  end
endmodule

// File: tb/bit_count_unit_tb.sv
module bit_count_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] opA = '0;
  logic [1:0]  opSel = 2'b10;
  logic [5:0]  countOut;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bit_count_unit u_dut (.opA(opA), .opSel(opSel), .countOut(countOut));

  typedef struct packed {
    logic [1:0]  sel;
    logic [31:0] a;
    logic [5:0]  exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 32'h0000_0000, 6'd32},
    '{2'b01, 32'h0000_0000, 6'd32},
    '{2'b10, 32'h0000_0000, 6'd0},
    '{2'b00, 32'hFFFF_FFFF, 6'd0},
    '{2'b01, 32'hFFFF_FFFF, 6'd0},
    '{2'b10, 32'hFFFF_FFFF, 6'd32},
    '{2'b00, 32'h0001_0000, 6'd15},
    '{2'b01, 32'h0001_0000, 6'd16},
    '{2'b10, 32'hF0F0_0001, 6'd9},
    '{2'b11, 32'hF0F0_0001, 6'd9},
    '{2'b00, 32'h0000_0001, 6'd31},
    '{2'b01, 32'h8000_0000, 6'd31}
  };

  function automatic logic [5:0] refCount(input logic [1:0] sel, input logic [31:0] a);
    int n = 0;
    if (sel[1]) begin
      for (int i = 0; i < 32; i++) if (a[i]) n++;
    end else if (sel == 2'b01) begin
      for (int i = 0; i < 32; i++) begin
        if (a[i]) break;
        n++;
      end
    end else begin
      for (int i = 31; i >= 0; i--) begin
        if (a[i]) break;
        n++;
      end
    end
    return 6'(n);
  endfunction

  task automatic apply(input logic [1:0] sel, input logic [31:0] a, input logic [5:0] exp,
                       input string req);
    @(negedge clk);
    opSel = sel;
    opA = a;
    #5;
    checks++;
    if (countOut !== exp) begin
      failures++;
      $display("FAIL %s sel=%b a=%h actual=%0d expected=%0d", req, sel, a, countOut, exp);
    end
  endtask

  function automatic string reqOf(input logic [1:0] sel);
    return sel[1] ? (sel[0] ? "R6" : "R1") : (sel[0] ? "R2" : "R3");
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    // R7: after reset, zero operand with pop select gives 0 with no clocking
    checks++;
    if (countOut !== 6'd0) begin
      failures++;
      $display("FAIL R7 reset-state actual=%0d expected=0", countOut);
    end
    rst = 1'b0;
    // R4 R5 R1 R2 R3 R6 table
    for (int k = 0; k < NV; k++) apply(VECS[k].sel, VECS[k].a, VECS[k].exp, "R4/R5 table");
    // single bit at each position, R2 R3 R1
    for (int p = 0; p < 32; p++) begin
      apply(2'b01, 32'h1 << p, 6'(p), "R2");
      apply(2'b00, 32'h1 << p, 6'(31 - p), "R3");
      apply(2'b10, 32'h1 << p, 6'd1, "R1");
    end
    // alternating patterns
    for (int s = 0; s < 4; s++) begin
      automatic logic [31:0] pat = (s == 0) ? 32'hAAAA_AAAA : (s == 1) ? 32'h5555_5555 :
                                   (s == 2) ? 32'hCCCC_CCCC : 32'h3333_3333;
      automatic logic [1:0] sel = 2'(s);
      for (int o = 0; o < 4; o++) apply(2'(o), pat, refCount(2'(o), pat), reqOf(2'(o)));
      apply(sel, ~pat, refCount(sel, ~pat), reqOf(sel));
    end
    // R7: output follows select change alone, same operand
    apply(2'b01, 32'h0000_0100, 6'd8, "R7");
    apply(2'b00, 32'h0000_0100, 6'd23, "R7");
    // random operands, R8 bound checked with each
    for (int r = 0; r < 400; r++) begin
      automatic logic [31:0] a = $urandom();
      automatic logic [1:0] sel = 2'($urandom_range(0, 3));
      if (r % 3 == 0) a = a >> $urandom_range(0, 31);
      if (r % 5 == 0) a = a << $urandom_range(0, 31);
      apply(sel, a, refCount(sel, a), reqOf(sel));
      checks++;
      if (countOut > 6'd32) begin
        failures++;
        $display("FAIL R8 actual=%0d expected<=32", countOut);
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule